// File: doc/BRIEF.md
# Two-Channel Prescaled Pulse Generator

This block produces two independent pulse-width-modulated outputs. A single 32-bit control word holds both channels' settings, with one 10-bit field per channel. Each channel also has its own word for period and duty. A channel divides the system clock by a divisor picked from a fixed code table and counts prescaled ticks from zero up to its programmed period. It drives its output to the chosen active level while the count is below the duty value.

Software uses a simple word-addressed port. Period and duty writes go to a shadow copy. The running channel picks up the shadow copy only when its current period ends, so a waveform is never cut mid-period. A read-only ready flag shows when a written value is still waiting to be picked up. A channel's divisor code can only change while its clock-gating bit is clear.

Top module: `pwm2_ctrl`

## Requirements
- R1: Word address 0 is the control word. Word address 1+n is channel n's timing word. Channel n's control field sits at bits [15n+9:15n] and reads back as written. Inside the field: [3:0] divisor code, 4 enable, 5 active level, 6 clock gating, 7 mode, 8 pulse, 9 bypass. The mode, pulse and bypass bits are stored only. All other control bits read 0, apart from the ready flags in R9.
- R2: Divisor codes 0,1,2,3,4 divide the clock by 120,180,240,360,480. Codes 8,9,10,11,12 divide by 12000,24000,36000,48000,72000. One period lasts (P+1)·divisor cycles, where P is timing-word bits [31:16].
- R3: Codes 5,6,7,13,14 are invalid. With an invalid code the channel stops: its output holds the inactive level and its count stays at zero.
- R4: Code 15 divides by 1, so the count advances on every clock.
- R5: A channel runs only when both enable and clock gating are 1. Otherwise its output holds the inactive level and its count returns to zero.
- R6: With active level 1, the output is high while the count is below the duty D (timing-word bits [15:0]) and low for the rest of the period. With active level 0, the output is the inverse of that. The inactive level is the inverse of the active-level bit.
- R7: D = 0 keeps the output inactive for the whole period. D ≥ P+1 keeps it active for the whole period.
- R8: A timing-word write goes to a shadow copy, and reads of that word return the shadow. A running channel copies the shadow into use in the cycle its count wraps from P to 0.
- R9: Control bit 28+n reads 1 from the cycle after a write to channel n's timing word until the copy of R8. While the channel is stopped, the copy happens on the next clock.
- R10: A write to the control word leaves channel n's divisor code unchanged if that channel's gating bit is 1 before the write. The field's other bits still update.
- R11: After reset every register is zero, both outputs are high (inactive with active level 0), and both ready flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | 2 | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed word (combinational) |
| pwm_out | output | 2 | Channel outputs, bit n for channel n |

## Verification
Some properties are checked by assertions on every cycle. A stopped channel never ticks and shows only its inactive level. The ready flag rises only after a write to that channel's timing word. A shadow copy happens only at a wrap or while the channel is stopped. The divisor code stays frozen while gating is set. Other behaviour can only be shown by the bench's scenarios, which compare against the reference model: the exact divisor values, including the slow 24000 divisor and the bypass code, the duty edge positions, the duty extremes, and the moment a mid-period update takes effect.

// File: rtl/pwm2_pkg.sv
package pwm2_pkg;
  localparam int FLD_STRIDE = 15;
  localparam int FLD_W      = 10;
  localparam int CODE_W     = 4;
  localparam int RDY_BASE   = 28;
  localparam int DIV_W      = 17;
  localparam int CNT_W      = 16;
  localparam int WORD_W     = 32;

  // Packed from MSB: bypass(9) pulse(8) mode(7) gate(6) level(5) enable(4) code[3:0]
  typedef struct packed {
    logic              byp;
    logic              pulse;
    logic              mode;
    logic              gate;
    logic              lvl;
    logic              en;
    logic [CODE_W-1:0] code;
  } chan_ctl_t;

  // Divisor for a code; zero marks an invalid code.
  function automatic logic [DIV_W-1:0] code_divisor(input logic [CODE_W-1:0] code);
    logic [DIV_W-1:0] d;
    case (code)
      4'd0:    d = 17'd120;
      4'd1:    d = 17'd180;
      4'd2:    d = 17'd240;
      4'd3:    d = 17'd360;
      4'd4:    d = 17'd480;
      4'd8:    d = 17'd12000;
      4'd9:    d = 17'd24000;
      4'd10:   d = 17'd36000;
      4'd11:   d = 17'd48000;
      4'd12:   d = 17'd72000;
      4'd15:   d = 17'd1;
      default: d = '0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/pwm2_prescaler.sv
module pwm2_prescaler
  import pwm2_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick
);
  logic [DIV_W-1:0] pc;

  assign tick = run && (pc == divisor - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n)              pc <= '0;
    else if (!run || tick)   pc <= '0;
    else                     pc <= pc + 1'b1;
  end
endmodule

// File: rtl/pwm2_channel.sv
module pwm2_channel
  import pwm2_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             lvl,
  input  logic             sh_wr,
  input  logic [CNT_W-1:0] wr_prd,
  input  logic [CNT_W-1:0] wr_dty,
  output logic [CNT_W-1:0] sh_prd,
  output logic [CNT_W-1:0] sh_dty,
  output logic             pend,
  output logic             wrap,
  output logic             load,
  output logic             pwm
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] prd_a;
  logic [CNT_W-1:0] dty_a;
  logic             active;

  assign wrap   = tick && (cnt == prd_a);
  assign load   = pend && (!run || wrap);
  assign active = run && (cnt < dty_a);
  assign pwm    = active ? lvl : ~lvl;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (wrap)  cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prd_a  <= '0;
      dty_a  <= '0;
      sh_prd <= '0;
      sh_dty <= '0;
      pend   <= 1'b0;
    end else begin
      if (load) begin
        prd_a <= sh_prd;
        dty_a <= sh_dty;
        pend  <= 1'b0;
      end
      if (sh_wr) begin
        sh_prd <= wr_prd;
        sh_dty <= wr_dty;
        pend   <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/pwm2_regs.sv
module pwm2_regs
  import pwm2_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [WORD_W-1:0]     wdata,
  input  logic [NCH-1:0]        pend,
  input  logic [NCH*CNT_W-1:0]  sh_prd,
  input  logic [NCH*CNT_W-1:0]  sh_dty,
  output chan_ctl_t [NCH-1:0]   ctl,
  output logic [NCH-1:0]        ch_wr,
  output logic [WORD_W-1:0]     rdata
);
  chan_ctl_t [NCH-1:0] ctl_nxt;
  logic                unused_wbits;

  assign unused_wbits = ^wdata;

  always_comb begin
    ctl_nxt = ctl;
    if (wr_en && addr == '0) begin
      for (int i = 0; i < NCH; i++) begin
        ctl_nxt[i] = chan_ctl_t'(wdata[i*FLD_STRIDE +: FLD_W]);
        if (ctl[i].gate) ctl_nxt[i].code = ctl[i].code;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ctl <= '0;
    else        ctl <= ctl_nxt;
  end

  for (genvar g = 0; g < NCH; g++) begin : g_wr
    assign ch_wr[g] = wr_en && (addr == ADDR_W'(g + 1));
  end

  always_comb begin
    rdata = '0;
    if (addr == '0) begin
      for (int i = 0; i < NCH; i++) begin
        rdata[i*FLD_STRIDE +: FLD_W] = ctl[i];
        rdata[RDY_BASE + i]          = pend[i];
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (addr == ADDR_W'(i + 1))
          rdata = {sh_prd[i*CNT_W +: CNT_W], sh_dty[i*CNT_W +: CNT_W]};
      end
    end
  end
endmodule

// File: rtl/pwm2_ctrl.sv
module pwm2_ctrl
  import pwm2_pkg::*;
#(
  parameter int NCH    = 2,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic [NCH-1:0]    pwm_out
);
  chan_ctl_t [NCH-1:0]   ctl;
  logic [NCH-1:0]        ch_wr;
  logic [NCH*CNT_W-1:0]  sh_prd;
  logic [NCH*CNT_W-1:0]  sh_dty;

  // Named internal events, observed by the bound checker
  logic [NCH-1:0]        ch_run;
  logic [NCH-1:0]        ch_tick;
  logic [NCH-1:0]        ch_wrap;
  logic [NCH-1:0]        ch_load;
  logic [NCH-1:0]        ch_pend;
  logic [NCH-1:0]        ch_lvl;
  logic [NCH-1:0]        ch_gate;
  logic [NCH*CODE_W-1:0] ch_code;

  pwm2_regs #(.NCH(NCH), .ADDR_W(ADDR_W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .addr   (addr),
    .wdata  (wdata),
    .pend   (ch_pend),
    .sh_prd (sh_prd),
    .sh_dty (sh_dty),
    .ctl    (ctl),
    .ch_wr  (ch_wr),
    .rdata  (rdata)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic [DIV_W-1:0] divisor;

    assign divisor    = code_divisor(ctl[g].code);
    assign ch_run[g]  = ctl[g].en && ctl[g].gate && (divisor != '0);
    assign ch_lvl[g]  = ctl[g].lvl;
    assign ch_gate[g] = ctl[g].gate;
    assign ch_code[g*CODE_W +: CODE_W] = ctl[g].code;

    pwm2_prescaler u_presc (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (ch_run[g]),
      .divisor (divisor),
      .tick    (ch_tick[g])
    );

    pwm2_channel u_chan (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (ch_run[g]),
      .tick   (ch_tick[g]),
      .lvl    (ch_lvl[g]),
      .sh_wr  (ch_wr[g]),
      .wr_prd (wdata[WORD_W-1:CNT_W]),
      .wr_dty (wdata[CNT_W-1:0]),
      .sh_prd (sh_prd[g*CNT_W +: CNT_W]),
      .sh_dty (sh_dty[g*CNT_W +: CNT_W]),
      .pend   (ch_pend[g]),
      .wrap   (ch_wrap[g]),
      .load   (ch_load[g]),
      .pwm    (pwm_out[g])
    );
  end
endmodule

// File: rtl/pwm2_ctrl_chk.sv
module pwm2_ctrl_chk #(
  parameter int NCH    = 2,
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [NCH-1:0]    pwm_out,
  input logic [NCH-1:0]    ch_run,
  input logic [NCH-1:0]    ch_tick,
  input logic [NCH-1:0]    ch_wrap,
  input logic [NCH-1:0]    ch_load,
  input logic [NCH-1:0]    ch_pend,
  input logic [NCH-1:0]    ch_lvl,
  input logic [NCH-1:0]    ch_gate,
  input logic [NCH*4-1:0]  ch_code
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    // R5
    tick_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_tick[i] |-> ch_run[i]);

    // R3
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ch_run[i] |-> (pwm_out[i] == ~ch_lvl[i]));

    // R9
    ready_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ch_pend[i]) |-> $past(wr_en && addr == ADDR_W'(i + 1)));

    // R8
    load_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_load[i] |-> (ch_wrap[i] || !ch_run[i]));

    // R8
    load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_load[i] && !(wr_en && addr == ADDR_W'(i + 1))) |=> !ch_pend[i]);

    // R10
    code_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_gate[i] |=> $stable(ch_code[i*4 +: 4]));
  end
endmodule

bind pwm2_ctrl pwm2_ctrl_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/pwm2_ctrl_tb.sv
module pwm2_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  pwm_out;

  int    n_cmp = 0;
  int    n_bad = 0;
  string phase = "R11 reset";

  always #4 clk = ~clk;

  pwm2_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pwm_out(pwm_out)
  );

  // Reference model state
  int m_code[2], m_en[2], m_lvl[2], m_gate[2], m_mode[2], m_pulse[2], m_byp[2];
  int m_sprd[2], m_sdty[2], m_aprd[2], m_adty[2], m_pend[2], m_cnt[2], m_pc[2];

  function automatic int mdiv(int c);
    case (c)
      0: return 120;   1: return 180;   2: return 240;
      3: return 360;   4: return 480;
      8: return 12000; 9: return 24000; 10: return 36000;
      11: return 48000; 12: return 72000;
      15: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit mrun(int ch);
    return (m_en[ch] != 0) && (m_gate[ch] != 0) && (mdiv(m_code[ch]) > 0);
  endfunction

  function automatic bit mout(int ch);
    bit act;
    act = mrun(ch) && (m_cnt[ch] < m_adty[ch]);
    return act ? (m_lvl[ch] != 0) : (m_lvl[ch] == 0);
  endfunction

  function automatic logic [31:0] mread(int a);
    logic [31:0] v;
    v = '0;
    if (a == 0) begin
      for (int ch = 0; ch < 2; ch++) begin
        v = v | (32'((m_code[ch] & 15) | (m_en[ch] << 4) | (m_lvl[ch] << 5) |
                 (m_gate[ch] << 6) | (m_mode[ch] << 7) | (m_pulse[ch] << 8) |
                 (m_byp[ch] << 9)) << (15 * ch));
        v = v | (32'(m_pend[ch]) << (28 + ch));
      end
    end else if (a <= 2) begin
      v = {m_sprd[a-1][15:0], m_sdty[a-1][15:0]};
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int ch = 0; ch < 2; ch++) begin
        m_code[ch] = 0; m_en[ch] = 0; m_lvl[ch] = 0; m_gate[ch] = 0;
        m_mode[ch] = 0; m_pulse[ch] = 0; m_byp[ch] = 0;
        m_sprd[ch] = 0; m_sdty[ch] = 0; m_aprd[ch] = 0; m_adty[ch] = 0;
        m_pend[ch] = 0; m_cnt[ch] = 0; m_pc[ch] = 0;
      end
    end else begin
      for (int ch = 0; ch < 2; ch++) begin
        int d; bit run; bit tk; bit wend; bit ld; int f;
        d    = mdiv(m_code[ch]);
        run  = mrun(ch);
        tk   = run && (m_pc[ch] == d - 1);
        wend = tk && (m_cnt[ch] == m_aprd[ch]);
        ld   = (m_pend[ch] != 0) && (!run || wend);
        m_pc[ch]  = (run && !tk) ? m_pc[ch] + 1 : 0;
        if (!run || wend) m_cnt[ch] = 0;
        else if (tk)      m_cnt[ch] = m_cnt[ch] + 1;
        if (ld) begin
          m_aprd[ch] = m_sprd[ch]; m_adty[ch] = m_sdty[ch]; m_pend[ch] = 0;
        end
        if (wr_en && int'(addr) == ch + 1) begin
          m_sprd[ch] = int'(wdata[31:16]); m_sdty[ch] = int'(wdata[15:0]);
          m_pend[ch] = 1;
        end
        if (wr_en && addr == 2'd0) begin
          f = int'(wdata >> (15 * ch));
          if (m_gate[ch] == 0) m_code[ch] = f & 15;
          m_en[ch] = (f >> 4) & 1;  m_lvl[ch] = (f >> 5) & 1;
          m_gate[ch] = (f >> 6) & 1; m_mode[ch] = (f >> 7) & 1;
          m_pulse[ch] = (f >> 8) & 1; m_byp[ch] = (f >> 9) & 1;
        end
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Every-cycle output comparison against the model
  always @(negedge clk) begin
    if (rst_n) begin
      for (int ch = 0; ch < 2; ch++)
        chk(phase, 32'(pwm_out[ch]), 32'(mout(ch)));
    end
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(string req, logic [1:0] a);
    @(negedge clk);
    addr = a;
    #1;
    chk(req, rdata, mread(int'(a)));
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 190000);
    chk("watchdog", 32'd1, 32'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    idle(5);
    rst_n = 1'b1;
    // R11: reset state read directly at the ports
    addr = 2'd0; #1;
    chk("R11 ctrl after reset", rdata, 32'h0);
    chk("R11 outputs after reset", 32'(pwm_out), 32'h3);
    addr = 2'd1; #1;
    chk("R11 timing word after reset", rdata, 32'h0);

    // R1: control fields, 15-bit stride, stray bits dropped
    phase = "R1 register map";
    wr(2'd0, 32'h3BF | (32'h13 << 15) | 32'h7C00 | 32'hE000_0000);
    addr = 2'd0; #1;
    chk("R1 ctrl readback", rdata, 32'h3BF | (32'h13 << 15));
    wr(2'd1, 32'h0009_0003);
    wr(2'd2, 32'h0001_0001);
    rd("R1 ch0 timing readback", 2'd1);
    rd("R1 ch1 timing readback", 2'd2);
    rd("R9 ctrl after stopped copy", 2'd0);

    // R4 R6: ch0 bypass active-high; R2: ch1 divide by 360, inverted
    phase = "R4 R6 R2 run";
    wr(2'd0, 32'h3FF | (32'h53 << 15));
    idle(1500);

    // R8 R7: mid-period update to full-duty value
    phase = "R8 R7 shadow update";
    wr(2'd1, 32'h0004_0005);
    rd("R9 ready while pending", 2'd0);
    addr = 2'd0; #1;
    chk("R9 ready bit 28 set", 32'(rdata[28]), 32'd1);
    idle(40);
    rd("R9 ready cleared after copy", 2'd0);

    phase = "R7 zero duty";
    wr(2'd1, 32'h0004_0000);
    idle(30);

    // R10: code change ignored while gating set
    phase = "R10 code frozen";
    wr(2'd0, 32'h070 | (32'h53 << 15));
    addr = 2'd0; #1;
    chk("R10 code kept at 15", 32'(rdata[3:0]), 32'hF);
    rd("R10 ctrl model", 2'd0);

    // R3: clear gating, then install invalid code 5
    phase = "R3 invalid code";
    wr(2'd1, 32'h0004_0002);
    wr(2'd0, 32'h02F | (32'h53 << 15));
    wr(2'd0, 32'h075 | (32'h53 << 15));
    addr = 2'd0; #1;
    chk("R3 code 5 stored", 32'(rdata[3:0]), 32'h5);
    idle(100);
    chk("R3 output inactive", 32'(pwm_out[0]), 32'd0);

    // R5: gating on, enable off
    phase = "R5 enable off";
    wr(2'd0, 32'h02F | (32'h53 << 15));
    wr(2'd0, 32'h06F | (32'h53 << 15));
    idle(60);
    chk("R5 output inactive", 32'(pwm_out[0]), 32'd0);

    // R2: slow divisor 24000 on ch0, two ticks per period
    phase = "R2 divide 24000";
    wr(2'd1, 32'h0001_0001);
    wr(2'd0, 32'h029 | (32'h53 << 15));
    wr(2'd0, 32'h079 | (32'h53 << 15));
    idle(50000);
    rd("R2 ctrl model", 2'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule